// File: doc/BRIEF.md
# Per-Core Thermal Frequency and Voltage Controller

This block sits beside one processor core. It holds the core close to a temperature ceiling and runs the core clock as fast as the silicon's timing allows. A programmable cycle counter produces a sample tick. On each tick the block reads a digitized core temperature and takes the difference from a programmable setpoint. A setpoint code of 85 stands for 85 °C, since one code step is one degree. The block then evaluates a fixed-point proportional-integral law on that difference. The result, clamped to a legal range, is loaded into the frequency word that feeds the external clock synthesizer.

Between ticks the thermal command is held. A one-bit warning from an external critical-path replica moves the frequency word down one step when it is set. When the warning is clear, the word moves up one step, unless the core is above the setpoint. A 16-row table, indexed by the top four bits of the frequency word, gives a supply voltage code that follows the square root of frequency. The voltage output can be forced to zero.

The synthesizer, the temperature converter, the regulator and the replica path all sit outside this block.

Top module: `thermal_dvfs_ctrl`

## Requirements
- R1: A synchronous reset clears the integrator to 0, loads the frequency word with N_MIN and restarts the sample counter, so the first tick comes `period_cfg` cycles after the reset is released.
- R2: A sample tick occurs once every `period_cfg` cycles (0 acts as 1). The integrator changes only on a tick.
- R3: On a tick the error is `setpoint - temp_in`, signed. The integrator adds the error and then saturates at +I_LIM and -I_LIM.
- R4: On a tick the frequency word becomes clamp((KP*err + KI*integ_new) >>> FRAC, N_MIN, N_MAX), where integ_new is the saturated new integrator value. The warning is ignored in that cycle.
- R5: On a non-tick cycle with `warn`=1, the frequency word falls by one, but not below N_MIN.
- R6: On a non-tick cycle with `warn`=0 and `hot`=0, the frequency word rises by one, but not above N_MAX.
- R7: `hot` is 1 exactly when `temp_in > setpoint`, combinationally. On a non-tick cycle with `hot`=1 and `warn`=0, the frequency word is held.
- R8: With `vout_en`=1, `vcode` equals table row `n_out[N_W-1:N_W-4]`, a combinational function of the current word. The default table row k is round(255*sqrt((k+1)/16)). With `vout_en`=0, `vcode` is 0.
- R9: `n_out` never leaves [N_MIN, N_MAX]. N_MAX is the word that corresponds to the maximum specified core frequency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| period_cfg | input | CNT_W | Sample period in cycles |
| setpoint | input | T_W | Temperature ceiling code |
| temp_in | input | T_W | Digitized core temperature |
| warn | input | 1 | Timing warning from the replica path |
| vout_en | input | 1 | Enables the voltage code output |
| n_out | output | N_W | Frequency word to the clock synthesizer |
| vcode | output | V_W | Voltage code to the regulator |
| hot | output | 1 | Core above setpoint |

## Verification
The bench builds the block with N_MIN=8 and N_MAX=250. With those values, a single upward ramp walks through every frequency word and every one of the 16 voltage rows. I_LIM=2000 makes the integrator reach saturation within about eight ticks at full-scale error, so windup and its recovery both fall inside a short run. The bench programs sample periods of 1000, 5, 3, 1 and 0. These cover a long stretch of pure nudging, ticks mixed with pseudo-random warnings, and the degenerate case where every cycle is a tick.

// File: rtl/tdvfs_pkg.sv
package tdvfs_pkg;
  // Default voltage rows for an 8-bit code: round(255*sqrt((k+1)/16)), row 15 in the top byte.
  localparam logic [127:0] VTAB_DEFAULT = {
    8'd255, 8'd247, 8'd239, 8'd230, 8'd221, 8'd211, 8'd202, 8'd191,
    8'd180, 8'd169, 8'd156, 8'd143, 8'd128, 8'd110, 8'd90,  8'd64
  };

  localparam int VROWS = 16;
  localparam int VIDX_W = 4;
endpackage

// File: rtl/tdvfs_tick.sv
module tdvfs_tick #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] period_cfg,
  output logic             tick
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  assign last = (period_cfg == '0) ? '0 : period_cfg - 1'b1;
  assign tick = (cnt_q >= last);

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end

  // R2: with a period above one, two ticks never follow each other
  p_tick_gap_r2: assert property (@(posedge clk) disable iff (rst)
    (tick && period_cfg > 1) |=> (!tick || !$stable(period_cfg)));
endmodule

// File: rtl/tdvfs_pi.sv
module tdvfs_pi #(
  parameter int T_W   = 8,
  parameter int I_W   = 16,
  parameter int I_LIM = 8000,
  parameter int KP    = 32,
  parameter int KI    = 15,
  parameter int FRAC  = 8,
  parameter int N_W   = 8,
  parameter int N_MIN = 16,
  parameter int N_MAX = 200
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic [T_W-1:0] setpoint,
  input  logic [T_W-1:0] temp_in,
  output logic [N_W-1:0] n_cmd
);
  localparam int ACC_W = I_W + 24;
  localparam logic signed [I_W:0]     SUM_HI = (I_W+1)'(I_LIM);
  localparam logic signed [I_W:0]     SUM_LO = -SUM_HI;
  localparam logic signed [I_W-1:0]   INT_HI = I_W'(I_LIM);
  localparam logic signed [I_W-1:0]   INT_LO = -INT_HI;
  localparam logic signed [ACC_W-1:0] KP_S   = ACC_W'(KP);
  localparam logic signed [ACC_W-1:0] KI_S   = ACC_W'(KI);
  localparam logic signed [ACC_W-1:0] NLO_S  = ACC_W'(N_MIN);
  localparam logic signed [ACC_W-1:0] NHI_S  = ACC_W'(N_MAX);

  logic signed [T_W:0]   err;
  logic signed [I_W-1:0] integ_q;
  logic signed [I_W-1:0] integ_nx;

  // integrator step with symmetric saturation
  function automatic logic signed [I_W-1:0] integ_step(
    input logic signed [I_W-1:0] cur,
    input logic signed [T_W:0]   e
  );
    logic signed [I_W:0] s;
    s = (I_W+1)'(cur) + (I_W+1)'(e);
    if (s > SUM_HI)      s = SUM_HI;
    else if (s < SUM_LO) s = SUM_LO;
    return I_W'(s);
  endfunction

  // PI law scaled to a synthesizer word, clamped to the legal window
  function automatic logic [N_W-1:0] pi_word(
    input logic signed [T_W:0]   e,
    input logic signed [I_W-1:0] i
  );
    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] u;
    acc = KP_S * ACC_W'(e) + KI_S * ACC_W'(i);
    u   = acc >>> FRAC;
    if (u < NLO_S)      return N_W'(N_MIN);
    else if (u > NHI_S) return N_W'(N_MAX);
    else                return N_W'(u);
  endfunction

  assign err      = $signed({1'b0, setpoint}) - $signed({1'b0, temp_in});
  assign integ_nx = integ_step(integ_q, err);
  assign n_cmd    = pi_word(err, integ_nx);

  always_ff @(posedge clk) begin
    if (rst)       integ_q <= '0;
    else if (tick) integ_q <= integ_nx;
  end

  p_integ_bound_r3: assert property (@(posedge clk) disable iff (rst)
    (integ_q <= INT_HI) && (integ_q >= INT_LO));
  p_integ_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(integ_q));
  p_integ_reset_r1: assert property (@(posedge clk)
    rst |=> (integ_q == '0));
endmodule

// File: rtl/tdvfs_nreg.sv
module tdvfs_nreg #(
  parameter int N_W   = 8,
  parameter int N_MIN = 16,
  parameter int N_MAX = 200
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic [N_W-1:0] n_cmd,
  input  logic           warn,
  input  logic           hot,
  output logic [N_W-1:0] n_q
);
  localparam logic [N_W-1:0] N_LO = N_W'(N_MIN);
  localparam logic [N_W-1:0] N_HI = N_W'(N_MAX);

  logic step_dn;
  logic step_up;

  assign step_dn = !tick && warn && (n_q > N_LO);
  assign step_up = !tick && !warn && !hot && (n_q < N_HI);

  always_ff @(posedge clk) begin
    if (rst)          n_q <= N_LO;
    else if (tick)    n_q <= n_cmd;
    else if (step_dn) n_q <= n_q - 1'b1;
    else if (step_up) n_q <= n_q + 1'b1;
  end

  p_n_window_r9: assert property (@(posedge clk) disable iff (rst)
    (n_q >= N_LO) && (n_q <= N_HI));
  p_down_one_r5: assert property (@(posedge clk) disable iff (rst)
    (!tick && warn && n_q > N_LO) |=> (n_q + 1 == $past(n_q)));
  p_up_one_r6: assert property (@(posedge clk) disable iff (rst)
    (!tick && !warn && !hot && n_q < N_HI) |=> (n_q == $past(n_q) + 1));
  p_hot_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!tick && !warn && hot) |=> $stable(n_q));
  p_n_reset_r1: assert property (@(posedge clk)
    rst |=> (n_q == N_LO));
endmodule

// File: rtl/tdvfs_vlut.sv
module tdvfs_vlut
  import tdvfs_pkg::*;
#(
  parameter int V_W = 8,
  parameter logic [VROWS*V_W-1:0] V_TABLE = VTAB_DEFAULT
) (
  input  logic [VIDX_W-1:0] idx,
  input  logic              en,
  output logic [V_W-1:0]    vcode
);
  logic [V_W-1:0] rows [VROWS];

  for (genvar k = 0; k < VROWS; k++) begin : g_row
    assign rows[k] = V_TABLE[k*V_W +: V_W];
  end

  assign vcode = en ? rows[idx] : '0;

  always_comb begin
    if (!en) a_vcode_off_r8: assert (vcode == '0);
  end
endmodule

// File: rtl/thermal_dvfs_ctrl.sv
module thermal_dvfs_ctrl
  import tdvfs_pkg::*;
#(
  parameter int T_W   = 8,
  parameter int N_W   = 8,
  parameter int V_W   = 8,
  parameter int CNT_W = 16,
  parameter int I_W   = 16,
  parameter int I_LIM = 8000,
  parameter int KP    = 32,
  parameter int KI    = 15,
  parameter int FRAC  = 8,
  parameter int N_MIN = 16,
  parameter int N_MAX = 200,
  parameter logic [VROWS*V_W-1:0] V_TABLE = VTAB_DEFAULT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] period_cfg,
  input  logic [T_W-1:0]   setpoint,
  input  logic [T_W-1:0]   temp_in,
  input  logic             warn,
  input  logic             vout_en,
  output logic [N_W-1:0]   n_out,
  output logic [V_W-1:0]   vcode,
  output logic             hot
);
  logic           tick;
  logic [N_W-1:0] n_cmd;

  assign hot = (temp_in > setpoint);

  tdvfs_tick #(.CNT_W(CNT_W)) u_tick (
    .clk(clk), .rst(rst), .period_cfg(period_cfg), .tick(tick)
  );

  tdvfs_pi #(
    .T_W(T_W), .I_W(I_W), .I_LIM(I_LIM), .KP(KP), .KI(KI), .FRAC(FRAC),
    .N_W(N_W), .N_MIN(N_MIN), .N_MAX(N_MAX)
  ) u_pi (
    .clk(clk), .rst(rst), .tick(tick), .setpoint(setpoint),
    .temp_in(temp_in), .n_cmd(n_cmd)
  );

  tdvfs_nreg #(.N_W(N_W), .N_MIN(N_MIN), .N_MAX(N_MAX)) u_nreg (
    .clk(clk), .rst(rst), .tick(tick), .n_cmd(n_cmd),
    .warn(warn), .hot(hot), .n_q(n_out)
  );

  tdvfs_vlut #(.V_W(V_W), .V_TABLE(V_TABLE)) u_vlut (
    .idx(n_out[N_W-1 -: VIDX_W]), .en(vout_en), .vcode(vcode)
  );

  // R4: a tick loads the PI command whatever the warning says
  p_tick_load_r4: assert property (@(posedge clk) disable iff (rst)
    tick |=> (n_out == $past(n_cmd)));
endmodule

// File: tb/thermal_dvfs_ctrl_tb.sv
`timescale 1ns/1ps
module thermal_dvfs_ctrl_tb_top;
  localparam int NMIN = 8, NMAX = 250, KP = 32, KI = 15, FRAC = 8, ILIM = 2000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] period_cfg = 16'd1000;
  logic [7:0]  setpoint = 8'd85;
  logic [7:0]  temp_in = 8'd60;
  logic        warn = 1'b0;
  logic        vout_en = 1'b1;
  logic [7:0]  n_out, vcode;
  logic        hot;

  int checks = 0, fails = 0;
  int m_cnt = 0, m_int = 0, m_n = NMIN;
  string phase = "R1";

  always #2.5 clk = ~clk;

  thermal_dvfs_ctrl #(
    .N_MIN(NMIN), .N_MAX(NMAX), .I_LIM(ILIM), .KP(KP), .KI(KI), .FRAC(FRAC)
  ) dut_i (
    .clk(clk), .rst(rst), .period_cfg(period_cfg), .setpoint(setpoint),
    .temp_in(temp_in), .warn(warn), .vout_en(vout_en),
    .n_out(n_out), .vcode(vcode), .hot(hot)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // nearest-integer 255*sqrt((k+1)/16): (2v-1)^2*16 <= 4*65025*(k+1) < (2v+1)^2*16
  function automatic int vexp(input int k);
    for (int v = 0; v < 256; v++)
      if ((2*v-1)*(2*v-1)*16 <= 4*65025*(k+1) && 4*65025*(k+1) < (2*v+1)*(2*v+1)*16)
        return v;
    return -1;
  endfunction

  task automatic model_edge();
    int last, err, s, u;
    if (rst) begin
      m_cnt = 0; m_int = 0; m_n = NMIN;
    end else begin
      last = (period_cfg == 0) ? 0 : int'(period_cfg) - 1;
      if (m_cnt >= last) begin
        m_cnt = 0;
        err = int'(setpoint) - int'(temp_in);
        s = m_int + err;
        if (s > ILIM) s = ILIM;
        if (s < -ILIM) s = -ILIM;
        m_int = s;
        u = (KP*err + KI*m_int) >>> FRAC;
        m_n = (u < NMIN) ? NMIN : (u > NMAX) ? NMAX : u;
      end else begin
        m_cnt++;
        if (warn) begin
          if (m_n > NMIN) m_n--;
        end else if (!(temp_in > setpoint)) begin
          if (m_n < NMAX) m_n++;
        end
      end
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    model_edge();
    @(posedge clk);
    #1;
    chk(phase, int'(n_out), m_n);
    chk("R7", int'(hot), (temp_in > setpoint) ? 1 : 0);
    chk("R8", int'(vcode), vout_en ? vexp(m_n >> 4) : 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] lfsr = 8'hA5;
    // R1: reset state
    phase = "R1";
    cyc(); cyc();
    chk("R1", int'(n_out), NMIN);
    rst = 1'b0;
    // R6: climb one step per cycle to the ceiling (walks every table row, R8)
    phase = "R6";
    for (int i = 0; i < 250; i++) cyc();
    chk("R9", int'(n_out), NMAX);
    // R5: warning walks the word down to the floor
    phase = "R5"; warn = 1'b1;
    for (int i = 0; i < 250; i++) cyc();
    chk("R9", int'(n_out), NMIN);
    // R7: hot blocks upward nudges
    phase = "R7"; warn = 1'b0; temp_in = 8'd90;
    for (int i = 0; i < 40; i++) cyc();
    chk("R7", int'(n_out), NMIN);
    // R8: voltage output disabled
    phase = "R8"; temp_in = 8'd70; vout_en = 1'b0;
    for (int i = 0; i < 20; i++) cyc();
    vout_en = 1'b1;
    // R4: PI ticks every 5 cycles with pseudo-random warnings over a temperature sweep
    phase = "R4"; period_cfg = 16'd5; rst = 1'b1; cyc(); rst = 1'b0;
    for (int t = 0; t < 256; t += 15) begin
      temp_in = 8'(t);
      for (int j = 0; j < 20; j++) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        warn = lfsr[0];
        cyc();
      end
    end
    // R3: windup at full error, then recovery with negative error
    phase = "R3"; period_cfg = 16'd3; warn = 1'b0; setpoint = 8'd255; temp_in = 8'd0;
    for (int i = 0; i < 60; i++) cyc();
    setpoint = 8'd85; temp_in = 8'd200;
    for (int i = 0; i < 60; i++) cyc();
    // R2: every cycle is a tick for period 0 and 1; warnings have no effect
    phase = "R2";
    for (int p = 0; p < 2; p++) begin
      period_cfg = 16'(p);
      for (int i = 0; i < 30; i++) begin
        temp_in = 8'(60 + 3*i); warn = i[0];
        cyc();
      end
    end
    // R1: mid-run reset, then first tick after a full period
    phase = "R1"; period_cfg = 16'd7; rst = 1'b1; cyc();
    chk("R1", int'(n_out), NMIN);
    rst = 1'b0; temp_in = 8'd40; setpoint = 8'd85;
    for (int i = 0; i < 20; i++) cyc();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule